// File: doc/BRIEF.md
# Banked Pin Interrupt Controller with Debounce Filter

This block serves one bank of external pin interrupts. Every line passes through a two-flop synchronizer and a per-line debounce filter. The filter looks at the line only on a shared sample tick. That tick comes from one of two oscillator pulse inputs, the slow one or the fast one, divided by a programmable power of two. Behind the filter, each line has its own trigger mode, a sticky pending flag and an enable bit. The bank drives one summary interrupt to the parent controller. That interrupt is high while any enabled line has its flag set.

Software reaches the block through a simple synchronous bus. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. A read is requested with `bus_sel` high and `bus_wr` low, and `bus_rdata` holds the result from the following cycle. Pending flags are cleared by writing a one to them. Flags set for every line that fires, whether or not the line is enabled.

The filter of each line is a two-state machine. In DB_SETTLED, a sample tick that finds the synchronized pin different from the filtered value moves the machine to DB_PROBE. In DB_PROBE, the next sample tick always returns it to DB_SETTLED. If that tick still sees the new value, the filtered value takes it; if not, the change is dropped.

Top module: `gpio_irq_bank`

## Requirements
- R1: Register map, by word address. Addresses 0 to 3 hold the mode words. Line i uses word i/8, bits 4*(i%8)+3 down to 4*(i%8). Address 4 is the enable register, address 5 the pending-flag register and address 6 the filter register. A read of address 7 returns 0. A read returns the register value in the cycle after the request.
- R2: Mode codes 0 (rising), 1 (falling) and 2 (either edge) set the line's flag once, one cycle after the sample tick where the filtered value makes the matching transition.
- R3: Mode codes 3 (high) and 4 (low) set the flag one cycle after every sample tick where the filtered level matches. After a clear, the flag therefore sets again if the level is still present. Codes 5 to 15 never set the flag.
- R4: Writing a 1 to a bit of the pending-flag register clears that flag. Writing a 0 leaves the flag as it is. A hardware set in the same cycle wins over the clear.
- R5: A flag sets even when its line is disabled. `irq_out` is high exactly when some line has both its flag and its enable bit set.
- R6: A write to the enable register that turns a line's bit from 0 to 1 also clears that line's flag in the same cycle, unless hardware sets the flag in that cycle.
- R7: The filtered value of a line changes only when two consecutive sample ticks both see the new synchronized value. An input that holds for at most one sample tick is ignored.
- R8: The filter register holds the source select in bit 0 (0 = `slow_tick`, 1 = `fast_tick`) and the exponent n in bits 6 to 4. One sample tick occurs per 2^n pulses of the selected source. Any write to this register restarts the count.
- R9: After reset, every mode word, the enable register, the pending flags and the filter register read 0, and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_tick | input | 1 | One-cycle pulse from the slow oscillator |
| fast_tick | input | 1 | One-cycle pulse from the fast oscillator |
| pin_in | input | 32 | External pin levels, asynchronous |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the request |
| irq_out | output | 1 | Summary interrupt of the bank |

## Verification
All five trigger modes run side by side on separate lines. Static levels, single rising steps and falling steps show edge modes apart from level modes. They also show that an unused code stays silent. Short pulses at a slow sample rate show the filter apart from a plain synchronizer. Clears while a level is held, clears with a zero mask, and re-enables of masked lines show the write-one-to-clear path apart from the enable-clear path. Switching the source and the exponent changes the spacing of every event that `irq_out` shows, and the bench compares `irq_out` with its model on every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // trigger mode codes held in each 4-bit field
    localparam logic [3:0] TRIG_RISE = 4'd0;
    localparam logic [3:0] TRIG_FALL = 4'd1;
    localparam logic [3:0] TRIG_BOTH = 4'd2;
    localparam logic [3:0] TRIG_HIGH = 4'd3;
    localparam logic [3:0] TRIG_LOW  = 4'd4;

    // word addresses
    localparam int ADDR_W        = 3;
    localparam int MODE_WORDS    = 4;
    localparam logic [ADDR_W-1:0] A_ENABLE   = 3'd4;
    localparam logic [ADDR_W-1:0] A_PENDING  = 3'd5;
    localparam logic [ADDR_W-1:0] A_FILTER   = 3'd6;

    // filter register layout
    localparam int FLT_SRC_BIT = 0;
    localparam int FLT_EXP_LSB = 4;

    typedef enum logic {
        DB_SETTLED,
        DB_PROBE
    } db_state_e;

    function automatic logic trig_fire(input logic [3:0] code,
                                       input logic now,
                                       input logic was);
        logic f;
        case (code)
            TRIG_RISE: f = now & ~was;
            TRIG_FALL: f = ~now & was;
            TRIG_BOTH: f = now ^ was;
            TRIG_HIGH: f = now;
            TRIG_LOW:  f = ~now;
            default:   f = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_irq_prescaler.sv
module gpio_irq_prescaler #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             use_fast,
    input  logic             slow_tick,
    input  logic             fast_tick,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             sample_tick
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    logic             src;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        src   = use_fast ? fast_tick : slow_tick;
        limit = (CNT_W'(1) << exp_sel) - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            sample_tick <= 1'b0;
        end else if (restart) begin
            cnt         <= '0;
            sample_tick <= 1'b0;
        end else begin
            sample_tick <= 1'b0;
            if (src) begin
                if (cnt == limit) begin
                    cnt         <= '0;
                    sample_tick <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    // R8: a tick follows a counted source pulse
    a_r8_tick_from_source: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> $past(src && !restart));
endmodule

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_tick,
    input  logic [NUM_LINES-1:0] pin_sync,
    output logic [NUM_LINES-1:0] deb_now,
    output logic [NUM_LINES-1:0] deb_before,
    output logic                 deb_upd
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        db_state_e st_q, st_n;
        logic      val_n;
        logic      differ;

        assign differ = pin_sync[i] ^ deb_now[i];

        always_comb begin
            st_n  = st_q;
            val_n = deb_now[i];
            if (sample_tick) begin
                unique case (st_q)
                    DB_SETTLED: if (differ) st_n = DB_PROBE;
                    DB_PROBE: begin
                        st_n = DB_SETTLED;
                        if (differ) val_n = pin_sync[i];
                    end
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q       <= DB_SETTLED;
                deb_now[i] <= 1'b0;
            end else begin
                st_q       <= st_n;
                deb_now[i] <= val_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deb_before <= '0;
            deb_upd    <= 1'b0;
        end else begin
            deb_upd <= sample_tick;
            if (sample_tick) deb_before <= deb_now;
        end
    end

    // R7: filtered values move only in the cycle flagged as an update
    a_r7_change_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(deb_now) |-> deb_upd);
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES*4-1:0] mode_flat,
    input  logic [NUM_LINES-1:0]   deb_now,
    input  logic [NUM_LINES-1:0]   deb_before,
    input  logic                   deb_upd,
    input  logic [NUM_LINES-1:0]   clr_mask,
    input  logic [NUM_LINES-1:0]   reen_mask,
    output logic [NUM_LINES-1:0]   status
);
    logic [NUM_LINES-1:0] hit;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_hit
        assign hit[i] = deb_upd & trig_fire(mode_flat[i*4 +: 4], deb_now[i], deb_before[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~(clr_mask | reen_mask)) | hit;
    end

    // R4: a one written with no hardware set clears the flag
    a_r4_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask & ~hit)) |=> ((status & $past(clr_mask & ~hit)) == '0));
    // R4: hardware set wins over any clear
    a_r4_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((status & $past(hit)) == $past(hit)));
    // R2 / R3: a flag only rises after a trigger
    a_r3_set_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(hit)) == '0));
    // R6: re-enable clears the flag
    a_r6_reenable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(reen_mask & ~hit)) |=> ((status & $past(reen_mask & ~hit)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int EXP_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slow_tick,
    input  logic                 fast_tick,
    input  logic [NUM_LINES-1:0] pin_in,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic                 irq_out
);
    localparam int PAD_W = NUM_LINES - FLT_EXP_LSB - EXP_W;

    logic [NUM_LINES*4-1:0] mode_flat;
    logic [NUM_LINES-1:0]   enable_q;
    logic                   flt_fast;
    logic [EXP_W-1:0]       flt_exp;

    logic                   wr_en, rd_en;
    logic [NUM_LINES-1:0]   clr_mask, reen_mask;
    logic                   restart;
    logic [NUM_LINES-1:0]   pin_sync, deb_now, deb_before, status;
    logic                   sample_tick, deb_upd;
    logic [NUM_LINES-1:0]   rd_mux;

    assign wr_en     = bus_sel & bus_wr;
    assign rd_en     = bus_sel & ~bus_wr;
    assign clr_mask  = (wr_en && bus_addr == A_PENDING) ? bus_wdata : '0;
    assign reen_mask = (wr_en && bus_addr == A_ENABLE) ? (bus_wdata & ~enable_q) : '0;
    assign restart   = wr_en && bus_addr == A_FILTER;

    gpio_irq_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync));

    gpio_irq_prescaler #(.EXP_W(EXP_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .restart(restart), .use_fast(flt_fast),
        .slow_tick(slow_tick), .fast_tick(fast_tick), .exp_sel(flt_exp),
        .sample_tick(sample_tick));

    gpio_irq_debounce #(.NUM_LINES(NUM_LINES)) u_deb (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .pin_sync(pin_sync),
        .deb_now(deb_now), .deb_before(deb_before), .deb_upd(deb_upd));

    gpio_irq_status #(.NUM_LINES(NUM_LINES)) u_stat (
        .clk(clk), .rst_n(rst_n), .mode_flat(mode_flat), .deb_now(deb_now),
        .deb_before(deb_before), .deb_upd(deb_upd), .clr_mask(clr_mask),
        .reen_mask(reen_mask), .status(status));

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_flat <= '0;
            enable_q  <= '0;
            flt_fast  <= 1'b0;
            flt_exp   <= '0;
        end else if (wr_en) begin
            if (int'(bus_addr) < MODE_WORDS)
                mode_flat[int'(bus_addr[1:0])*NUM_LINES +: NUM_LINES] <= bus_wdata;
            else if (bus_addr == A_ENABLE)
                enable_q <= bus_wdata;
            else if (bus_addr == A_FILTER) begin
                flt_fast <= bus_wdata[FLT_SRC_BIT];
                flt_exp  <= bus_wdata[FLT_EXP_LSB +: EXP_W];
            end
        end
    end

    always_comb begin
        if (int'(bus_addr) < MODE_WORDS)
            rd_mux = mode_flat[int'(bus_addr[1:0])*NUM_LINES +: NUM_LINES];
        else if (bus_addr == A_ENABLE)  rd_mux = enable_q;
        else if (bus_addr == A_PENDING) rd_mux = status;
        else if (bus_addr == A_FILTER)  rd_mux = {{PAD_W{1'b0}}, flt_exp, 3'b000, flt_fast};
        else                            rd_mux = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_mux;
    end

    assign irq_out = |(status & enable_q);

    // R5: nothing enabled, nothing raised
    a_r5_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> !irq_out);
endmodule

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/100ps
module gpio_irq_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0, fast_tick = 1'b0;
    logic [31:0] pin_in = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int total = 0, bad = 0, cyc = 0;
    bit run_cmp = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_bank uut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .pin_in(pin_in), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

    // oscillator pulses: fast every 2 cycles, slow every 8
    always @(negedge clk) begin
        cyc++;
        fast_tick <= (cyc % 2 == 0);
        slow_tick <= (cyc % 8 == 0);
    end

    // ---------------- behavioural reference model ----------------
    logic [31:0]  m_s1, m_s2, m_deb, m_old, m_probe, m_status, m_en, m_rdata;
    logic [127:0] m_mode;
    logic         m_fast, m_tick, m_upd;
    logic [2:0]   m_exp;
    int           m_cnt;

    function automatic bit fires(int code, bit now, bit was);
        case (code)
            0: return now && !was;
            1: return !now && was;
            2: return now != was;
            3: return now;
            4: return !now;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        bit src;
        bit wr;
        logic [31:0] nxt;
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_deb <= '0; m_old <= '0; m_probe <= '0;
            m_status <= '0; m_en <= '0; m_rdata <= '0; m_mode <= '0;
            m_fast <= 0; m_tick <= 0; m_upd <= 0; m_exp <= '0; m_cnt <= 0;
        end else begin
            wr  = bus_sel && bus_wr;
            m_s1 <= pin_in;
            m_s2 <= m_s1;
            src = m_fast ? fast_tick : slow_tick;
            if (wr && bus_addr == 6) begin
                m_cnt <= 0; m_tick <= 0;
            end else begin
                m_tick <= 0;
                if (src) begin
                    if (m_cnt == (1 << m_exp) - 1) begin m_cnt <= 0; m_tick <= 1; end
                    else m_cnt <= m_cnt + 1;
                end
            end
            if (m_tick) begin
                m_old <= m_deb;
                for (int i = 0; i < 32; i++) begin
                    if (!m_probe[i]) m_probe[i] <= (m_s2[i] != m_deb[i]);
                    else begin
                        m_probe[i] <= 1'b0;
                        if (m_s2[i] != m_deb[i]) m_deb[i] <= m_s2[i];
                    end
                end
            end
            m_upd <= m_tick;
            nxt = m_status;
            if (wr && bus_addr == 5) nxt = nxt & ~bus_wdata;
            if (wr && bus_addr == 4) nxt = nxt & ~(bus_wdata & ~m_en);
            for (int i = 0; i < 32; i++)
                if (m_upd && fires(int'(m_mode[i*4 +: 4]), m_deb[i], m_old[i])) nxt[i] = 1'b1;
            m_status <= nxt;
            if (wr) begin
                if (bus_addr < 4) m_mode[int'(bus_addr)*32 +: 32] <= bus_wdata;
                else if (bus_addr == 4) m_en <= bus_wdata;
                else if (bus_addr == 6) begin m_fast <= bus_wdata[0]; m_exp <= bus_wdata[6:4]; end
            end
            if (bus_sel && !bus_wr) begin
                case (bus_addr)
                    0, 1, 2, 3: m_rdata <= m_mode[int'(bus_addr)*32 +: 32];
                    4: m_rdata <= m_en;
                    5: m_rdata <= m_status;
                    6: m_rdata <= {25'd0, m_exp, 3'd0, m_fast};
                    default: m_rdata <= '0;
                endcase
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // R5: summary interrupt compared on every cycle
    always @(negedge clk)
        if (run_cmp) check({31'd0, irq_out}, {31'd0, |(m_status & m_en)}, "R5 irq_out per cycle");

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_reg(input logic [2:0] a, input string tag, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        v = bus_rdata;
        check(v, m_rdata, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] v;
        idle(3);
        rst_n = 1;
        run_cmp = 1;
        // R9 reset state
        for (int a = 0; a < 7; a++) begin
            rd_reg(3'(a), "R9 reset register", v);
            check(v, 32'h0, "R9 reset register literal");
        end
        check({31'd0, irq_out}, 32'h0, "R9 irq low after reset");

        // R8 fast source, exponent 0; R1 mode layout
        wr_reg(6, 32'h0000_0001);
        rd_reg(6, "R8 filter readback", v);
        check(v, 32'h1, "R8 filter literal");
        wr_reg(0, 32'h0074_3210);
        wr_reg(1, 32'h7777_7777);
        wr_reg(2, 32'h7777_7777);
        wr_reg(3, 32'h7777_7777);
        rd_reg(0, "R1 mode word 0", v);
        check(v, 32'h0074_3210, "R1 mode word literal");
        rd_reg(7, "R1 unused address", v);
        check(v, 32'h0, "R1 unused address literal");
        wr_reg(4, 32'h0000_003F);
        idle(20);
        rd_reg(5, "R3 low level sets", v);
        check(v & 32'h3F, 32'h10, "R3 only low-level line pending");

        // R2 edges
        pin_in[0] = 1; pin_in[2] = 1; pin_in[3] = 1; pin_in[5] = 1;
        idle(20);
        rd_reg(5, "R2 rising/both/high", v);
        check(v & 32'h2F, 32'h0D, "R2 R3 edge and level lines, code 7 silent");
        pin_in[1] = 1; idle(20);
        pin_in[1] = 0; idle(20);
        rd_reg(5, "R2 falling edge", v);
        check(v & 32'h2, 32'h2, "R2 falling line pending");

        // R4 clear all, R3 retrigger
        wr_reg(5, 32'hFFFF_FFFF);
        rd_reg(5, "R4 after clear", v);
        idle(20);
        rd_reg(5, "R3 level retriggers", v);
        check(v & 32'h18, 32'h18, "R3 held levels set again");
        check(v & 32'h2, 32'h0, "R4 edge line stays clear");
        wr_reg(5, 32'h0);
        rd_reg(5, "R4 zero write", v);
        check(v & 32'h18, 32'h18, "R4 zero write keeps flags");

        // R7 glitch filtering at slower sample rate
        wr_reg(6, 32'h0000_0031);
        wr_reg(5, 32'h0000_0040);
        idle(5);
        pin_in[6] = 1; idle(3); pin_in[6] = 0;
        idle(80);
        rd_reg(5, "R7 glitch ignored", v);
        check(v & 32'h40, 32'h0, "R7 short pulse ignored");
        pin_in[6] = 1; idle(80);
        rd_reg(5, "R7 steady input passes", v);
        check(v & 32'h40, 32'h40, "R7 steady input triggers");

        // R5 masked lines
        wr_reg(4, 32'h0);
        idle(2);
        check({31'd0, irq_out}, 32'h0, "R5 all masked, irq low");
        pin_in[1] = 1; idle(60); pin_in[1] = 0; idle(60);
        rd_reg(5, "R5 masked status still sets", v);
        check(v & 32'h2, 32'h2, "R5 masked line pending");

        // R6 re-enable clears
        wr_reg(4, 32'h0000_0002);
        rd_reg(5, "R6 re-enable clears", v);
        check(v & 32'h2, 32'h0, "R6 stale flag removed");
        wr_reg(4, 32'h0000_003F);

        // R8 slow source, exponent 2
        wr_reg(6, 32'h0000_0020);
        rd_reg(6, "R8 slow source readback", v);
        check(v, 32'h20, "R8 slow literal");
        wr_reg(5, 32'hFFFF_FFFF);
        pin_in[0] = 0; idle(150);
        pin_in[0] = 1; idle(150);
        rd_reg(5, "R8 slow sampled edge", v);
        check(v & 32'h1, 32'h1, "R8 rising seen on slow ticks");
        idle(10);
        run_cmp = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule